// File: doc/BRIEF.md
# Programmable Clock Divider and Output Controller

This block is the digital back end of a programmable clock generator. It receives a reference clock and an already synthesized clock. From these it builds two clock outputs. The first output picks one of three sources: the synthesized clock, the reference itself, or the reference divided by an even factor 2×P, where P is a 14-bit value. The second output picks the reference, the reference at half rate, the first output's source, or that source at half rate. The cascaded paths take the first output's source before its gating, so disabling the first output does not stop a second output that is derived from it.

A single external control pin takes one of three roles, chosen by configuration. It can act as an output enable for the first output, as an active-low power-down for both outputs, or as a frequency select that switches the divider between two stored factors. The block reports PLL-enable and oscillator-enable levels for the analog parts that sit around it. A disabled output either releases its enable, which gives high impedance, or drives a steady low, depending on one configuration bit. Each output is a data and output-enable pair, so a pad cell can be attached outside the block.

All configuration is static and is changed only while reset is held. The control pin is asynchronous. It passes through a synchronizer in the reference domain before it takes effect.

Top module: `clkout_ctrl`

## Requirements
- R1: With the first-output source set to divided (cfg_clk0_sel = 2), clk0_o has a period of 2×P reference cycles and is high for exactly P of them.
- R2: A divider factor of 0 behaves exactly like a factor of 1 (period of 2 reference cycles).
- R3: cfg_clk0_sel selects the first output's source: 0 = synthesized clock, 1 = reference clock, 2 or 3 = reference divided by 2×P.
- R4: cfg_clk1_sel selects the second output's source: 0 = reference, 1 = reference divided by two, 2 = first-output source, 3 = first-output source divided by two.
- R5: With cfg_pin_mode = 0 (output enable) and ctl_pin low, the first output is disabled within 3 reference cycles, pll_en is 0, osc_en is 1, and the second output keeps running with clk1_oe = 1.
- R6: With cfg_pin_mode = 1 (power-down) and ctl_pin low, both outputs are disabled within 3 reference cycles, and pll_en and osc_en are both 0.
- R7: A disabled output holds its data at 0. Its output enable is 0 when cfg_dis_low = 0 (high impedance) and 1 when cfg_dis_low = 1 (driven low).
- R8: With cfg_pin_mode = 2 or 3 (frequency select), ctl_pin high selects factor cfg_p_a and ctl_pin low selects cfg_p_b. A new factor is adopted only at a divided-clock toggle, so no high or low phase of clk0_o is shorter than the smaller factor.
- R9: With ctl_pin high, or in frequency-select mode at either pin level, both outputs run with their enables at 1, and pll_en = osc_en = 1.
- R10: While rst is high, both outputs are in the configured disabled state and produce no edges, and the divider is held cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; clocks the divider, the synchronizer and the enables |
| synth_clk | input | 1 | Already synthesized clock, a source for the first output |
| rst | input | 1 | Synchronous active-high reset (the half-rate cascade flop clears asynchronously) |
| cfg_p_a | input | 14 | Divider factor used normally, and when the pin is high in frequency-select mode |
| cfg_p_b | input | 14 | Divider factor used when the pin is low in frequency-select mode |
| cfg_clk0_sel | input | 2 | First-output source select |
| cfg_clk1_sel | input | 2 | Second-output source select |
| cfg_pin_mode | input | 2 | Control pin role: 0 output enable, 1 power-down, 2/3 frequency select |
| cfg_dis_low | input | 1 | Disabled style: 0 high impedance, 1 driven low |
| ctl_pin | input | 1 | Asynchronous multi-function control pin; high when unconnected |
| clk0_o | output | 1 | First clock output data |
| clk0_oe | output | 1 | First clock output enable |
| clk1_o | output | 1 | Second clock output data |
| clk1_oe | output | 1 | Second clock output enable |
| pll_en | output | 1 | Enable for the external PLL |
| osc_en | output | 1 | Enable for the external oscillator |

## Verification
The assertions assume that configuration inputs stay constant outside reset. A factor change or a mode change that arrives while the block runs would break the relation between the pin mode and the registered enables, and the period checks of the divider. The bench changes configuration only between raising and releasing rst. It moves ctl_pin on falling reference edges and waits more than the synchronizer depth before it judges any gating. The synthesized clock runs free, at a phase that never lines up with the bench's sampling instants.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int P_W   = 14;
    localparam int N_OUT = 2;

    typedef enum logic [1:0] {
        PIN_OE    = 2'd0,
        PIN_PWRDN = 2'd1,
        PIN_FSEL  = 2'd2,
        PIN_FSEL2 = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        C0_SYNTH = 2'd0,
        C0_REF   = 2'd1,
        C0_DIV   = 2'd2,
        C0_DIV2  = 2'd3
    } c0_sel_e;

    typedef enum logic [1:0] {
        C1_REF      = 2'd0,
        C1_REF_HALF = 2'd1,
        C1_C0       = 2'd2,
        C1_C0_HALF  = 2'd3
    } c1_sel_e;

    typedef struct packed {
        logic en0;
        logic en1;
        logic pll_on;
        logic osc_on;
    } gate_t;

    function automatic logic is_fsel(pin_mode_e m);
        return (m == PIN_FSEL) || (m == PIN_FSEL2);
    endfunction

endpackage

// File: rtl/clkout_even_div.sv
module clkout_even_div #(
    parameter int PW = clkout_pkg::P_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] p_next,
    output logic          div_o
);

    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] p_fix;
    logic [PW-1:0] p_act_q;
    logic [PW-1:0] cnt_q;
    logic          div_q;
    logic          wrap;

    assign p_fix = (p_next == '0) ? ONE : p_next;
    assign wrap  = (cnt_q == p_act_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            div_q   <= 1'b0;
            p_act_q <= p_fix;
        end else if (wrap) begin
            cnt_q   <= '0;
            div_q   <= ~div_q;
            p_act_q <= p_fix;
        end else begin
            cnt_q   <= cnt_q + ONE;
        end
    end

    assign div_o = div_q;

    a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < p_act_q);

    a_r2_period_nonzero: assert property (@(posedge clk) disable iff (rst)
        p_act_q != '0);

    a_r8_period_held: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != p_act_q - ONE) |=> $stable(p_act_q));

    a_r1_toggle_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != p_act_q - ONE) |=> $stable(div_q));

endmodule

// File: rtl/clkout_pinctl.sv
module clkout_pinctl
    import clkout_pkg::*;
#(
    parameter int PW   = clkout_pkg::P_W,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin_raw,
    input  pin_mode_e     mode,
    input  logic [PW-1:0] p_a,
    input  logic [PW-1:0] p_b,
    output logic [PW-1:0] p_sel,
    output logic          en0_q,
    output logic          en1_q,
    output logic          pll_en,
    output logic          osc_en
);

    logic [SYNC-1:0] sync_q;
    logic            pin_s;
    gate_t           gate_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], pin_raw};
        end
    end

    assign pin_s = sync_q[SYNC-1];

    always_comb begin
        gate_c = '{en0: 1'b1, en1: 1'b1, pll_on: 1'b1, osc_on: 1'b1};
        case (mode)
            PIN_OE: begin
                if (!pin_s) begin
                    gate_c.en0    = 1'b0;
                    gate_c.pll_on = 1'b0;
                end
            end
            PIN_PWRDN: begin
                if (!pin_s) begin
                    gate_c = '{en0: 1'b0, en1: 1'b0, pll_on: 1'b0, osc_on: 1'b0};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en0_q <= 1'b0;
            en1_q <= 1'b0;
        end else begin
            en0_q <= gate_c.en0;
            en1_q <= gate_c.en1;
        end
    end

    assign pll_en = gate_c.pll_on;
    assign osc_en = gate_c.osc_on;
    assign p_sel  = (is_fsel(mode) && !pin_s) ? p_b : p_a;

    a_r5_oe_gates_first: assert property (@(posedge clk) disable iff (rst)
        (mode == PIN_OE && !pin_s) |=> (!en0_q && en1_q));

    a_r6_pd_gates_both: assert property (@(posedge clk) disable iff (rst)
        (mode == PIN_PWRDN && !pin_s) |=> (!en0_q && !en1_q));

    a_r9_fsel_never_gates: assert property (@(posedge clk) disable iff (rst)
        is_fsel(mode) |=> (en0_q && en1_q && pll_en && osc_en));

endmodule

// File: rtl/clkout_drive.sv
module clkout_drive (
    input  logic clk_src,
    input  logic en,
    input  logic drive_low,
    output logic pad_o,
    output logic pad_oe
);

    assign pad_o  = clk_src & en;
    assign pad_oe = en | drive_low;

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkout_pkg::*;
#(
    parameter int P_W         = clkout_pkg::P_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic           ref_clk,
    input  logic           synth_clk,
    input  logic           rst,
    input  logic [P_W-1:0] cfg_p_a,
    input  logic [P_W-1:0] cfg_p_b,
    input  logic [1:0]     cfg_clk0_sel,
    input  logic [1:0]     cfg_clk1_sel,
    input  logic [1:0]     cfg_pin_mode,
    input  logic           cfg_dis_low,
    input  logic           ctl_pin,
    output logic           clk0_o,
    output logic           clk0_oe,
    output logic           clk1_o,
    output logic           clk1_oe,
    output logic           pll_en,
    output logic           osc_en
);

    pin_mode_e        mode;
    logic [P_W-1:0]   p_sel;
    logic             en0_q;
    logic             en1_q;
    logic             div_clk;
    logic             ref_half_q;
    logic             c0_half_q;
    logic             c0_raw;
    logic             c1_raw;
    logic [N_OUT-1:0] src_v;
    logic [N_OUT-1:0] en_v;
    logic [N_OUT-1:0] pad_v;
    logic [N_OUT-1:0] oe_v;

    assign mode = pin_mode_e'(cfg_pin_mode);

    clkout_pinctl #(.PW(P_W), .SYNC(SYNC_STAGES)) u_ctl (
        .clk     (ref_clk),
        .rst     (rst),
        .pin_raw (ctl_pin),
        .mode    (mode),
        .p_a     (cfg_p_a),
        .p_b     (cfg_p_b),
        .p_sel   (p_sel),
        .en0_q   (en0_q),
        .en1_q   (en1_q),
        .pll_en  (pll_en),
        .osc_en  (osc_en)
    );

    clkout_even_div #(.PW(P_W)) u_div (
        .clk    (ref_clk),
        .rst    (rst),
        .p_next (p_sel),
        .div_o  (div_clk)
    );

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            ref_half_q <= 1'b0;
        end else begin
            ref_half_q <= ~ref_half_q;
        end
    end

    always_comb begin
        case (c0_sel_e'(cfg_clk0_sel))
            C0_SYNTH: c0_raw = synth_clk;
            C0_REF:   c0_raw = ref_clk;
            default:  c0_raw = div_clk;
        endcase
    end

    always_ff @(posedge c0_raw or posedge rst) begin
        if (rst) begin
            c0_half_q <= 1'b0;
        end else begin
            c0_half_q <= ~c0_half_q;
        end
    end

    always_comb begin
        case (c1_sel_e'(cfg_clk1_sel))
            C1_REF:      c1_raw = ref_clk;
            C1_REF_HALF: c1_raw = ref_half_q;
            C1_C0:       c1_raw = c0_raw;
            default:     c1_raw = c0_half_q;
        endcase
    end

    assign src_v = {c1_raw, c0_raw};
    assign en_v  = {en1_q, en0_q};

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_drv
            clkout_drive u_drv (
                .clk_src   (src_v[g]),
                .en        (en_v[g]),
                .drive_low (cfg_dis_low),
                .pad_o     (pad_v[g]),
                .pad_oe    (oe_v[g])
            );
        end
    endgenerate

    assign clk0_o  = pad_v[0];
    assign clk0_oe = oe_v[0];
    assign clk1_o  = pad_v[1];
    assign clk1_oe = oe_v[1];

endmodule

// File: tb/clkout_ctrl_test.sv
`timescale 1ns/100ps
module clkout_ctrl_test;

    localparam real REF_PERIOD = 10.0;
    localparam int  WIN        = 120;
    localparam int  SETTLE     = 200;

    logic        ref_clk = 1'b0;
    logic        synth_clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] cfg_p_a = 14'd3;
    logic [13:0] cfg_p_b = 14'd3;
    logic [1:0]  cfg_clk0_sel = 2'd2;
    logic [1:0]  cfg_clk1_sel = 2'd0;
    logic [1:0]  cfg_pin_mode = 2'd0;
    logic        cfg_dis_low = 1'b0;
    logic        ctl_pin = 1'b1;
    logic        clk0_o, clk0_oe, clk1_o, clk1_oe, pll_en, osc_en;

    int vectors = 0;
    int fails   = 0;
    int e0 = 0, e1 = 0;
    int c0, c1, h0;
    int run = 0, minrun = 1000;
    logic last0 = 1'b0;
    bit done = 0;

    clkout_ctrl uut (
        .ref_clk(ref_clk), .synth_clk(synth_clk), .rst(rst),
        .cfg_p_a(cfg_p_a), .cfg_p_b(cfg_p_b),
        .cfg_clk0_sel(cfg_clk0_sel), .cfg_clk1_sel(cfg_clk1_sel),
        .cfg_pin_mode(cfg_pin_mode), .cfg_dis_low(cfg_dis_low),
        .ctl_pin(ctl_pin),
        .clk0_o(clk0_o), .clk0_oe(clk0_oe), .clk1_o(clk1_o), .clk1_oe(clk1_oe),
        .pll_en(pll_en), .osc_en(osc_en)
    );

    always #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;
    initial begin
        #1.5;
        forever begin
            synth_clk = ~synth_clk;
            #2.0;
        end
    end

    always @(posedge clk0_o) e0++;
    always @(posedge clk1_o) e1++;

    always @(negedge ref_clk) begin
        if (clk0_o == last0) begin
            run++;
        end else begin
            if (run < minrun) minrun = run;
            run = 1;
            last0 = clk0_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic observe();
        @(negedge ref_clk);
        e0 = 0;
        e1 = 0;
        h0 = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge ref_clk);
            h0 += int'(clk0_o);
        end
        c0 = e0;
        c1 = e1;
    endtask

    task automatic hold_reset();
        @(negedge ref_clk);
        rst = 1'b1;
    endtask

    task automatic release_reset();
        cycles(3);
        rst = 1'b0;
        cycles(SETTLE);
    endtask

    task automatic t_reset();
        hold_reset();
        cfg_pin_mode = 2'd0; ctl_pin = 1'b1; cfg_clk0_sel = 2'd1;
        cfg_clk1_sel = 2'd0; cfg_dis_low = 1'b0;
        cycles(3);
        observe();
        chk("R10 clk0 edges in reset", c0, 0);
        chk("R10 clk1 edges in reset", c1, 0);
        chk("R10 clk0_oe hiz in reset", int'(clk0_oe), 0);
        chk("R10 clk1_oe hiz in reset", int'(clk1_oe), 0);
        cfg_dis_low = 1'b1;
        cycles(1);
        chk("R10 clk0_oe low-drive in reset", int'(clk0_oe), 1);
        chk("R10 clk0_o low in reset", int'(clk0_o), 0);
        cfg_clk0_sel = 2'd2; cfg_p_a = 14'd3;
        observe();
        chk("R10 divider held in reset", c0, 0);
        release_reset();
        observe();
        chk("R9 clk0_oe after reset", int'(clk0_oe), 1);
        chk("R10 divider restarts after reset", c0, WIN / 6);
    endtask

    task automatic t_divide(input int p, input int exp_period);
        hold_reset();
        cfg_pin_mode = 2'd0; ctl_pin = 1'b1; cfg_clk0_sel = 2'd2;
        cfg_p_a = 14'(p); cfg_p_b = 14'd7; cfg_dis_low = 1'b0;
        release_reset();
        observe();
        if (p == 0) begin
            chk("R2 zero factor edges", c0, WIN / exp_period);
            chk("R2 zero factor high time", h0, WIN / 2);
        end else begin
            chk($sformatf("R1 P=%0d edges", p), c0, WIN / exp_period);
            chk($sformatf("R1 P=%0d high time", p), h0, WIN / 2);
        end
    endtask

    task automatic t_clk0_sel();
        hold_reset();
        cfg_pin_mode = 2'd0; ctl_pin = 1'b1; cfg_p_a = 14'd3;
        cfg_clk0_sel = 2'd0;
        release_reset();
        observe();
        chk("R3 sel0 synth edges", c0, WIN * 10 / 4);
        hold_reset();
        cfg_clk0_sel = 2'd1;
        release_reset();
        observe();
        chk("R3 sel1 ref edges", c0, WIN);
        hold_reset();
        cfg_clk0_sel = 2'd3;
        release_reset();
        observe();
        chk("R3 sel3 divided edges", c0, WIN / 6);
    endtask

    task automatic t_clk1_sel(input int sel, input int c0sel, input int exp);
        hold_reset();
        cfg_pin_mode = 2'd0; ctl_pin = 1'b1; cfg_p_a = 14'd2;
        cfg_clk0_sel = 2'(c0sel); cfg_clk1_sel = 2'(sel);
        release_reset();
        observe();
        chk($sformatf("R4 clk1 sel%0d clk0 sel%0d edges", sel, c0sel), c1, exp);
    endtask

    task automatic t_oe(input logic low_drive);
        hold_reset();
        cfg_pin_mode = 2'd0; ctl_pin = 1'b1; cfg_clk0_sel = 2'd1;
        cfg_clk1_sel = 2'd0; cfg_dis_low = low_drive;
        release_reset();
        ctl_pin = 1'b0;
        cycles(6);
        observe();
        chk("R5 clk0 stopped", c0, 0);
        chk("R7 clk0 data low", h0, 0);
        chk("R7 clk0_oe disabled style", int'(clk0_oe), int'(low_drive));
        chk("R5 clk1 still running", c1, WIN);
        chk("R5 clk1_oe on", int'(clk1_oe), 1);
        chk("R5 pll_en off", int'(pll_en), 0);
        chk("R5 osc_en on", int'(osc_en), 1);
        ctl_pin = 1'b1;
        cycles(6);
        observe();
        chk("R9 clk0 back after pin high", c0, WIN);
        chk("R9 pll_en back", int'(pll_en), 1);
    endtask

    task automatic t_pd(input logic low_drive);
        hold_reset();
        cfg_pin_mode = 2'd1; ctl_pin = 1'b1; cfg_clk0_sel = 2'd1;
        cfg_clk1_sel = 2'd1; cfg_dis_low = low_drive;
        release_reset();
        observe();
        chk("R9 pd mode pin high clk1", c1, WIN / 2);
        chk("R9 pd mode pin high osc_en", int'(osc_en), 1);
        ctl_pin = 1'b0;
        cycles(6);
        observe();
        chk("R6 clk0 stopped", c0, 0);
        chk("R6 clk1 stopped", c1, 0);
        chk("R7 clk0_oe disabled style", int'(clk0_oe), int'(low_drive));
        chk("R7 clk1_oe disabled style", int'(clk1_oe), int'(low_drive));
        chk("R7 clk1 data low", int'(clk1_o), 0);
        chk("R6 pll_en off", int'(pll_en), 0);
        chk("R6 osc_en off", int'(osc_en), 0);
        ctl_pin = 1'b1;
        cycles(6);
    endtask

    task automatic t_fsel(input int mode);
        hold_reset();
        cfg_pin_mode = 2'(mode); ctl_pin = 1'b1; cfg_clk0_sel = 2'd2;
        cfg_clk1_sel = 2'd0; cfg_p_a = 14'd2; cfg_p_b = 14'd5; cfg_dis_low = 1'b0;
        release_reset();
        observe();
        chk("R8 pin high uses P_A", c0, WIN / 4);
        @(negedge ref_clk);
        #1 minrun = 1000;
        ctl_pin = 1'b0;
        cycles(40);
        observe();
        chk("R8 pin low uses P_B", c0, WIN / 10);
        chk("R9 fsel pin low clk0_oe", int'(clk0_oe), 1);
        chk("R9 fsel pin low pll_en", int'(pll_en), 1);
        chk("R9 fsel pin low osc_en", int'(osc_en), 1);
        ctl_pin = 1'b1;
        cycles(40);
        observe();
        chk("R8 back to P_A", c0, WIN / 4);
        chk("R8 no runt phase", int'(minrun >= 2), 1);
    endtask

    initial begin
        #(REF_PERIOD * 200000.0);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_divide(3, 6);
        t_divide(5, 10);
        t_divide(1, 2);
        t_divide(0, 2);
        t_divide(60, 120);
        t_clk0_sel();
        t_clk1_sel(0, 2, WIN);
        t_clk1_sel(1, 2, WIN / 2);
        t_clk1_sel(2, 2, WIN / 4);
        t_clk1_sel(3, 2, WIN / 8);
        t_clk1_sel(3, 0, WIN * 10 / 8);
        t_oe(1'b0);
        t_oe(1'b1);
        t_pd(1'b0);
        t_pd(1'b1);
        t_fsel(2);
        t_fsel(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule